// File: doc/BRIEF.md
# Column-Skipping Readout Controller for a Shared-Wire Pixel Matrix

This controller scans a pixel matrix whose pixels connect to the periphery only through wires shared along rows and columns. Each column has a wired-OR line that rises when any pixel in it holds a hit. Each row has a wired-OR line that shows the pixel of the one column currently enabled. The controller drives two sets of reset lines: one line per row and one per column. The combination of the two selects the operation on each pixel: collect, frozen, read onto the row bus, or clear.

While idle, the matrix collects hits. A start strobe freezes the whole matrix for one hold cycle, which fixes the event's time window. During that hold cycle the controller latches the column OR vector. It then visits only the flagged columns, lowest index first. Each visit has one read cycle, which places the column on the row bus, and one clear cycle, which wipes that column. Every read produces one hit word holding the column index and the row pattern. After the last visited column, the controller returns to collection and gives a one-cycle completion pulse.

The states are SAMPLE (collect), HOLD (freeze and latch columns), READ and CLEAR. The transitions are:
- SAMPLE→HOLD on start.
- HOLD→READ when any column is flagged.
- HOLD→SAMPLE when no column is flagged.
- READ→CLEAR always.
- CLEAR→READ while flagged columns remain.
- CLEAR→SAMPLE after the last column.

Top module: `pxscan_ctrl`

## Requirements
- R1: After reset the block is in SAMPLE. All row reset lines are 1, all column reset lines are 0, and hit_valid_o and scan_done_o are 0.
- R2: A start_i seen in SAMPLE makes the next cycle HOLD, with all row and column reset lines at 0. A start_i seen in any other state has no effect on the scan sequence or its length.
- R3: The column OR vector present during the HOLD cycle decides which columns are visited. Bit c of col_or_i stands for column c.
- R4: Flagged columns are visited in ascending index order, and unflagged columns are never visited.
- R5: In a READ cycle all row reset lines are 0 and exactly one column reset line is 1: the one for the visited column.
- R6: The cycle after each READ is CLEAR. In CLEAR all row reset lines are 1 and the same single column reset line stays 1.
- R7: The cycle after each READ, hit_valid_o is 1 for one cycle. hit_col_o then holds the visited column index, and bit r of hit_row_o holds the row bus value for row r during that READ. hit_valid_o is 0 in every other cycle.
- R8: With K flagged columns, scan_done_o is 1 for exactly one cycle. That cycle is 2K+1 cycles after the HOLD cycle, and the block is back in SAMPLE in it.
- R9: With no flagged column, the scan has no READ cycle. HOLD is followed directly by SAMPLE, with scan_done_o at 1.
- R10: From HOLD until the scan ends, the collect condition (all row lines 1 with all column lines 0) never appears, so the matrix stays frozen.
- R11: After a scan, every visited column has been cleared, and the column OR vector seen in the following SAMPLE cycle is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Freeze-and-scan request |
| col_or_i | input | N_COLS | Per-column wired-OR hit flags |
| row_or_i | input | N_ROWS | Shared row bus |
| rst_row_o | output | N_ROWS | Row reset lines |
| rst_col_o | output | N_COLS | Column reset lines |
| hit_valid_o | output | 1 | Hit word valid |
| hit_col_o | output | $clog2(N_COLS) | Column index of the hit word |
| hit_row_o | output | N_ROWS | Row pattern of the hit word |
| scan_done_o | output | 1 | One-cycle scan completion pulse |

## Verification
The bench builds the block with eight columns and four rows and connects it to a behavioural matrix. This size makes the boundary columns 0 and 7 easy to reach. It also allows a fully occupied scan of sixteen read and clear cycles, an empty scan, and sparse, alternating and clustered patterns whose skip order can be predicted exactly. A start strobe sent in the middle of a scan checks that the timing of the completion pulse is unchanged.

// File: rtl/pxscan_pkg.sv
package pxscan_pkg;
    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_HOLD   = 2'd1,
        PH_READ   = 2'd2,
        PH_CLEAR  = 2'd3
    } phase_e;
endpackage

// File: rtl/pxscan_pick.sv
module pxscan_pick #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_i,
    output logic [W-1:0] idx_o,
    output logic [N-1:0] onehot_o,
    output logic         any_o
);
    // lowest set bit wins
    always_comb begin
        logic found;
        found = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                idx_o = W'(i);
                found = 1'b1;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_oh
            if (g == 0) begin : g_first
                assign onehot_o[g] = req_i[g];
            end else begin : g_rest
                assign onehot_o[g] = req_i[g] & ~(|req_i[g-1:0]);
            end
        end
    endgenerate

    assign any_o = |req_i;
endmodule

// File: rtl/pxscan_drive.sv
module pxscan_drive
    import pxscan_pkg::*;
#(
    parameter int N_ROWS = 4,
    parameter int N_COLS = 8
) (
    input  phase_e            phase_i,
    input  logic [N_COLS-1:0] sel_i,
    output logic [N_ROWS-1:0] rst_row_o,
    output logic [N_COLS-1:0] rst_col_o
);
    always_comb begin
        unique case (phase_i)
            PH_SAMPLE: begin
                rst_row_o = '1;
                rst_col_o = '0;
            end
            PH_HOLD: begin
                rst_row_o = '0;
                rst_col_o = '0;
            end
            PH_READ: begin
                rst_row_o = '0;
                rst_col_o = sel_i;
            end
            PH_CLEAR: begin
                rst_row_o = '1;
                rst_col_o = sel_i;
            end
            default: begin
                rst_row_o = '1;
                rst_col_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/pxscan_hitcap.sv
module pxscan_hitcap #(
    parameter int N_ROWS = 4,
    parameter int CW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [CW-1:0]     col_i,
    input  logic [N_ROWS-1:0] row_i,
    output logic              valid_o,
    output logic [CW-1:0]     col_o,
    output logic [N_ROWS-1:0] row_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            col_o   <= '0;
            row_o   <= '0;
        end else begin
            valid_o <= cap_i;
            if (cap_i) begin
                col_o <= col_i;
                row_o <= row_i;
            end
        end
    end
endmodule

// File: rtl/pxscan_ctrl.sv
module pxscan_ctrl
    import pxscan_pkg::*;
#(
    parameter int N_COLS = 8,
    parameter int N_ROWS = 4,
    localparam int CW = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [N_COLS-1:0] col_or_i,
    input  logic [N_ROWS-1:0] row_or_i,
    output logic [N_ROWS-1:0] rst_row_o,
    output logic [N_COLS-1:0] rst_col_o,
    output logic              hit_valid_o,
    output logic [CW-1:0]     hit_col_o,
    output logic [N_ROWS-1:0] hit_row_o,
    output logic              scan_done_o
);
    phase_e            state, state_nx;
    logic [N_COLS-1:0] pending;
    logic [N_COLS-1:0] sel_oh;
    logic [CW-1:0]     sel_idx;
    logic              sel_any;
    logic [N_COLS-1:0] left_after;
    logic              done_nx;

    pxscan_pick #(.N(N_COLS)) u_pick (
        .req_i    (pending),
        .idx_o    (sel_idx),
        .onehot_o (sel_oh),
        .any_o    (sel_any)
    );

    assign left_after = pending & ~sel_oh;

    // next-state selection
    always_comb begin
        state_nx = state;
        done_nx  = 1'b0;
        unique case (state)
            PH_SAMPLE: if (start_i) state_nx = PH_HOLD;
            PH_HOLD: begin
                if (|col_or_i) begin
                    state_nx = PH_READ;
                end else begin
                    state_nx = PH_SAMPLE;
                    done_nx  = 1'b1;
                end
            end
            PH_READ: state_nx = PH_CLEAR;
            PH_CLEAR: begin
                if (|left_after) begin
                    state_nx = PH_READ;
                end else begin
                    state_nx = PH_SAMPLE;
                    done_nx  = 1'b1;
                end
            end
            default: state_nx = PH_SAMPLE;
        endcase
    end

    // state register with latched column flags and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= PH_SAMPLE;
            pending     <= '0;
            scan_done_o <= 1'b0;
        end else begin
            state       <= state_nx;
            scan_done_o <= done_nx;
            if (state == PH_HOLD) begin
                pending <= col_or_i;
            end else if (state == PH_CLEAR) begin
                pending <= left_after;
            end
        end
    end

    // output decode of the phase onto the shared wires
    pxscan_drive #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_drive (
        .phase_i   (state),
        .sel_i     (sel_oh),
        .rst_row_o (rst_row_o),
        .rst_col_o (rst_col_o)
    );

    pxscan_hitcap #(.N_ROWS(N_ROWS), .CW(CW)) u_hit (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (state == PH_READ),
        .col_i   (sel_idx),
        .row_i   (row_or_i),
        .valid_o (hit_valid_o),
        .col_o   (hit_col_o),
        .row_o   (hit_row_o)
    );

    // ---------------- assertions ----------------
    p_start_enters_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_SAMPLE && start_i) |=> (rst_row_o == '0 && rst_col_o == '0));

    p_read_has_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_READ) |-> (sel_any && $onehot(rst_col_o)));

    p_clear_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_READ) |=> (state == PH_CLEAR && $stable(rst_col_o) && (&rst_row_o)));

    p_pending_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_CLEAR) |=> ($countones(pending) + 1 == $countones($past(pending))));

    p_hit_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_READ) |=> hit_valid_o);

    p_hit_only_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid_o |-> state == PH_CLEAR);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |=> !scan_done_o);

    p_done_in_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done_o |-> (state == PH_SAMPLE));

    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_SAMPLE) |-> !((&rst_row_o) && rst_col_o == '0));
endmodule

// File: tb/pxscan_ctrl_bench.sv
`timescale 1ns/1ps
module pxscan_ctrl_bench;
    localparam int NC = 8;
    localparam int NR = 4;
    localparam int CW = 3;
    localparam int NP = NC * NR;
    localparam int NV = 7;
    // pixel (r,c) is bit r*NC+c
    localparam logic [NP-1:0] PATS [NV] = '{
        32'h0000_0000,   // empty
        32'h0000_0001,   // col 0 row 0 only
        32'h8000_0000,   // col 7 row 3 only
        32'hFFFF_FFFF,   // every pixel
        32'h0055_0055,   // even columns, rows 0 and 2
        32'h0018_1800,   // cluster cols 3-4
        32'h8100_0042    // scattered
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NC-1:0] col_or;
    logic [NR-1:0] row_or;
    logic [NR-1:0] rst_row;
    logic [NC-1:0] rst_col;
    logic          hit_valid;
    logic [CW-1:0] hit_col;
    logic [NR-1:0] hit_row;
    logic          scan_done;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pxscan_ctrl #(.N_COLS(NC), .N_ROWS(NR)) u_pxscan_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .col_or_i    (col_or),
        .row_or_i    (row_or),
        .rst_row_o   (rst_row),
        .rst_col_o   (rst_col),
        .hit_valid_o (hit_valid),
        .hit_col_o   (hit_col),
        .hit_row_o   (hit_row),
        .scan_done_o (scan_done)
    );

    // behavioural matrix: collects only in the collect condition
    logic [NP-1:0] pix;
    logic [NP-1:0] inj = '0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix <= '0;
        end else begin
            for (int r = 0; r < NR; r++) begin
                for (int c = 0; c < NC; c++) begin
                    if (rst_row[r] && rst_col[c])
                        pix[r*NC+c] <= 1'b0;
                    else if ((&rst_row) && rst_col == '0 && inj[r*NC+c])
                        pix[r*NC+c] <= 1'b1;
                end
            end
        end
    end
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            col_or[c] = 1'b0;
            for (int r = 0; r < NR; r++) col_or[c] = col_or[c] | pix[r*NC+c];
        end
        for (int r = 0; r < NR; r++) begin
            row_or[r] = 1'b0;
            for (int c = 0; c < NC; c++) row_or[r] = row_or[r] | (pix[r*NC+c] & rst_col[c]);
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [NP-1:0] p);
        @(negedge clk);
        inj = p;
        @(negedge clk);
        inj = '0;
    endtask

    task automatic run_scan(input logic [NP-1:0] p, input bit mid_start);
        int cols [NC];
        int k;
        logic [NR-1:0] rows;
        k = 0;
        for (int c = 0; c < NC; c++) begin
            logic any;
            any = 1'b0;
            for (int r = 0; r < NR; r++) any = any | p[r*NC+c];
            if (any) begin
                cols[k] = c;
                k++;
            end
        end
        load(p);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // m = 1: hold cycle
        chk(rst_row == '0 && rst_col == '0, "R2 hold lines", {rst_row, rst_col}, 0);
        for (int m = 2; m <= 2*k + 2; m++) begin
            if (mid_start && m == 3) start = 1'b1;
            if (mid_start && m == 4) start = 1'b0;
            @(negedge clk);
            if (m == 2*k + 2) begin
                chk(scan_done == 1'b1, "R8/R9 done pulse", scan_done, 1);
                chk((&rst_row) && rst_col == '0, "R8 back in sample", {rst_row, rst_col}, 0);
                chk(hit_valid == 1'b0, "R7 no hit in sample", hit_valid, 0);
            end else begin
                int j;
                logic [NC-1:0] oh;
                j = (m - 2) / 2;
                oh = NC'(1) << cols[j];
                chk(scan_done == 1'b0, "R8 no early done", scan_done, 0);
                chk(!((&rst_row) && rst_col == '0), "R10 frozen", {rst_row, rst_col}, 0);
                if (m % 2 == 0) begin
                    chk(rst_row == '0 && rst_col == oh, "R4/R5 read lines", rst_col, oh);
                    chk(hit_valid == 1'b0, "R7 no hit in read", hit_valid, 0);
                end else begin
                    for (int r = 0; r < NR; r++) rows[r] = p[r*NC+cols[j]];
                    chk((&rst_row) && rst_col == oh, "R6 clear lines", rst_col, oh);
                    chk(hit_valid == 1'b1, "R7 hit valid", hit_valid, 1);
                    chk(int'(hit_col) == cols[j], "R3/R4 hit column", hit_col, cols[j]);
                    chk(hit_row == rows, "R7 hit rows", hit_row, rows);
                end
            end
        end
        @(negedge clk);
        chk(scan_done == 1'b0, "R8 single pulse", scan_done, 0);
        chk(col_or == '0, "R11 matrix cleared", col_or, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk((&rst_row) && rst_col == '0, "R1 reset lines", {rst_row, rst_col}, 0);
        chk(hit_valid == 1'b0 && scan_done == 1'b0, "R1 reset flags", {hit_valid, scan_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk((&rst_row) && rst_col == '0 && !scan_done, "R1 idle after reset", {rst_row, rst_col}, 0);
        // table walk
        for (int v = 0; v < NV; v++) run_scan(PATS[v], 1'b0);
        // R2: start inside a scan changes nothing
        run_scan(32'h1020_4080, 1'b1);
        // R9: empty scan again, then hits loaded after it are still seen
        run_scan('0, 1'b0);
        run_scan(32'h0000_8001, 1'b0);
        // R1: reset in the middle of a scan
        load(32'h0F00_0000);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk((&rst_row) && rst_col == '0 && !hit_valid, "R1 reset mid scan", {rst_row, rst_col}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule